// File: doc/BRIEF.md
# Programmable packet output arbiter

This block is one output port of a wormhole mesh router. Five input ports (North, South, East, West, Local) compete for it, and the block decides which of them sends its next packet. Only whole packets are arbitrated. When the first flit of a packet is granted, that input keeps the output until the flit tagged as end of packet has gone. Every flit crosses the output on a valid/ready handshake. When `out_ready` is low, the selected input sees `in_ready` low and keeps its flit, so nothing is lost or duplicated.

The `prog_mode` pin selects one of two policies. With the pin low, the output runs a round-robin arbiter, so every input requesting the port is served in turn and none starves. With the pin high, the output follows a stream of orders. Each order names one input through `ord_port` and is qualified by `ord_val`. The block grants a packet only to the input named by the pending order. It raises `ord_ack` in the cycle the first flit of that packet passes, which consumes the order. The next order can be presented while a packet is still being sent, so the order stream keeps pace with the traffic.

The policy is applied only at packet boundaries. A mode change or a new order presented during a packet has no effect on that packet.

Top module: `pkt_out_arbiter`

## Requirements
- R1: Inputs are indexed North=0, South=1, East=2, West=3, Local=4. A flit moves from input i when `in_valid[i]` and `in_ready[i]` are both high. At most one `in_ready` bit is high, and only while `out_ready` is high.
- R2: In fair mode (`prog_mode`=0) an idle output grants the first requesting input after the one it last granted in fair mode, searching cyclically by index. After reset the search starts at index 0. Grants made in programmed mode do not move this pointer.
- R3: Once the first flit of a packet is granted and is not marked end of packet, only that input may send until its `in_eop`-tagged flit has transferred. A packet whose first flit carries `in_eop` takes a single cycle.
- R4: In programmed mode (`prog_mode`=1) a packet is granted only to the input whose index 0..4 is on `ord_port` while `ord_val` is high. Packets leave in the order of the order stream.
- R5: A new order presented while a packet is in flight does not alter, stall or reorder that packet.
- R6: `ord_ack` is high exactly in the cycle in which the first flit of the ordered packet transfers. There is one acknowledge per order, and `ord_ack` is never high in fair mode.
- R7: In programmed mode the output stays idle (`out_valid`=0) while no valid order is pending, or while the ordered input has no flit, even if other inputs request.
- R8: `ord_port` codes 5, 6 and 7 are never acknowledged, and while such an order is pending no packet is granted.
- R9: `prog_mode` is sampled only when the output is idle and a first flit is being granted. Switching it during a packet neither cuts nor extends that packet.
- R10: While `out_ready` is low no flit is consumed. `out_valid`, `out_data` and `out_eop` follow the granted input. After reset `out_valid`, `ord_ack` and every `in_ready` bit are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_mode | input | 1 | 1: follow the order stream, 0: round-robin |
| in_valid | input | N_IN | Per-input flit valid |
| in_ready | output | N_IN | Per-input flit accept |
| in_data | input | N_IN*DATA_W | Per-input flit payload, input i at bits i*DATA_W upward |
| in_eop | input | N_IN | Per-input end-of-packet tag of the presented flit |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream accept |
| out_data | output | DATA_W | Output flit payload |
| out_eop | output | 1 | Output end-of-packet tag |
| ord_val | input | 1 | Order on `ord_port` is valid |
| ord_port | input | 3 | Index of the input whose packet is granted next |
| ord_ack | output | 1 | Order consumed: its first flit passed this cycle |

## Verification
The bench builds the block with its default parameters: five inputs and a 16-bit flit. This leaves enough room to pack the source index, a packet number and a flit index into every payload word, so each flit seen at the output can be traced to one expected packet. Five inputs let the round-robin pointer wrap fully across both full and sparse request sets. The 3-bit order field keeps the spare codes 5 to 7 within reach of the stimulus. Mode switches are made in the middle of long packets in both directions, and a periodic back-pressure pattern shows that stalls cost no flits.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;

  localparam int unsigned NUM_PORTS  = 5;
  localparam int unsigned FLIT_WIDTH = 16;

  typedef enum logic [2:0] {
    SRC_NORTH = 3'd0,
    SRC_SOUTH = 3'd1,
    SRC_EAST  = 3'd2,
    SRC_WEST  = 3'd3,
    SRC_LOCAL = 3'd4
  } src_id_e;

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [IW-1:0] pick,
  output logic          any
);

  logic [IW-1:0] last_q;

  // lowest cyclic distance after last_q wins
  always_comb begin
    pick = last_q;
    any  = 1'b0;
    for (int off = N; off >= 1; off--) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (req[idx]) begin
        pick = IW'(idx);
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                last_q <= IW'(N - 1);
    else if (advance && any)   last_q <= pick;
  end

  assert_pick_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[pick]);

endmodule

// File: rtl/order_gate.sv
module order_gate #(
  parameter int unsigned N  = 5,
  parameter int unsigned IW = 3
) (
  input  logic          ord_val,
  input  logic [IW-1:0] ord_port,
  input  logic [N-1:0]  req,
  output logic [IW-1:0] sel,
  output logic          ok
);

  // codes beyond N-1 never match an input, so they never grant
  always_comb begin
    sel = ord_port;
    ok  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ord_port == IW'(i) && req[i]) ok = ord_val;
    end
  end

endmodule

// File: rtl/pkt_out_arbiter.sv
module pkt_out_arbiter
  import pkt_arb_pkg::*;
#(
  parameter  int unsigned N_IN   = NUM_PORTS,
  parameter  int unsigned DATA_W = FLIT_WIDTH,
  localparam int unsigned PORT_W = $clog2(N_IN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_mode,
  input  logic [N_IN-1:0]          in_valid,
  output logic [N_IN-1:0]          in_ready,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  input  logic [N_IN-1:0]          in_eop,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_eop,
  input  logic                     ord_val,
  input  logic [PORT_W-1:0]        ord_port,
  output logic                     ord_ack
);

  localparam logic [PORT_W-1:0] TOP_IDX = PORT_W'(N_IN - 1);

  logic              busy_q;
  logic [PORT_W-1:0] owner_q;

  logic [PORT_W-1:0] fair_idx, prog_idx, cand, sel;
  logic              fair_any, prog_ok, cand_ok, active;
  logic              sel_valid, fire, first_fire;

  rr_picker #(.N(N_IN), .IW(PORT_W)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (in_valid),
    .advance (first_fire && !prog_mode),
    .pick    (fair_idx),
    .any     (fair_any)
  );

  order_gate #(.N(N_IN), .IW(PORT_W)) u_order (
    .ord_val  (ord_val),
    .ord_port (ord_port),
    .req      (in_valid),
    .sel      (prog_idx),
    .ok       (prog_ok)
  );

  // candidate for the next packet, only consulted while idle
  assign cand    = prog_mode ? prog_idx : fair_idx;
  assign cand_ok = prog_mode ? prog_ok  : fair_any;

  assign sel    = busy_q ? owner_q : cand;
  assign active = busy_q || cand_ok;

  always_comb begin
    out_data  = '0;
    out_eop   = 1'b0;
    sel_valid = 1'b0;
    in_ready  = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel == PORT_W'(i)) begin
        out_data    = in_data[i*DATA_W +: DATA_W];
        out_eop     = in_eop[i];
        sel_valid   = in_valid[i];
        in_ready[i] = out_ready && active;
      end
    end
  end

  assign out_valid  = active && sel_valid;
  assign fire       = out_valid && out_ready;
  assign first_fire = fire && !busy_q;
  assign ord_ack    = first_fire && prog_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (first_fire && !out_eop) begin
      busy_q  <= 1'b1;
      owner_q <= cand;
    end else if (busy_q && fire && out_eop) begin
      busy_q  <= 1'b0;
    end
  end

  assert_ready_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready) && (out_ready || in_ready == '0));

  assert_owner_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eop) |=> ((in_ready & ~$past(in_ready)) == '0));

  assert_ack_with_flit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ord_ack |-> (prog_mode && out_valid && out_ready && ord_val));

  assert_idle_without_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !busy_q && !ord_val) |-> !out_valid);

  assert_no_ack_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_port > TOP_IDX) |-> !ord_ack);

endmodule

// File: tb/pkt_out_arbiter_tb.sv
`timescale 1ns/1ps
module pkt_out_arbiter_tb;

  localparam int N  = 5;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            prog_mode;
  logic [N-1:0]    in_valid, in_ready, in_eop;
  logic [N*DW-1:0] in_data;
  logic            out_valid, out_ready, out_eop;
  logic [DW-1:0]   out_data;
  logic            ord_val, ord_ack;
  logic [2:0]      ord_port;

  always #4 clk = ~clk;

  pkt_out_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eop(out_eop),
    .ord_val(ord_val), .ord_port(ord_port), .ord_ack(ord_ack)
  );

  logic [16:0] srcq [N][$];
  int          pend [N][$];
  logic [2:0]  ordq [$];
  logic [17:0] expq [$];

  int       checks = 0, fails = 0, cyc = 0, rr_m = N - 1;
  logic     src_en = 1'b0, bp = 1'b0, mode_r = 1'b0;
  logic [N-1:0] fire_src = '0;
  logic     fire_ord = 1'b0;
  string    tag = "R1";

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // driver and monitor: pops at the falling edge, drives at +1, samples at +2
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) if (fire_src[i]) void'(srcq[i].pop_front());
    if (fire_ord) void'(ordq.pop_front());
    fire_src = '0;
    fire_ord = 1'b0;
    #1;
    for (int i = 0; i < N; i++) begin
      in_valid[i] = src_en && (srcq[i].size() > 0);
      in_data[i*DW +: DW] = in_valid[i] ? srcq[i][0][15:0] : '0;
      in_eop[i] = in_valid[i] ? srcq[i][0][16] : 1'b0;
    end
    ord_val   = ordq.size() > 0;
    ord_port  = ord_val ? ordq[0] : 3'd0;
    out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
    prog_mode = mode_r;
    #1;
    for (int i = 0; i < N; i++) fire_src[i] = in_valid[i] && in_ready[i];
    fire_ord = ord_val && ord_ack;
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, {tag, " unexpected flit"}, {14'd0, ord_ack, out_eop, out_data}, 32'd0);
      end else begin
        logic [17:0] e;
        e = expq.pop_front();
        chk({ord_ack, out_eop, out_data} == e, tag, {14'd0, ord_ack, out_eop, out_data}, {14'd0, e});
      end
    end else if (rst_n && ord_ack) begin
      chk(1'b0, "R6 acknowledge without flit", 32'd1, 32'd0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // data word: source[15:13] packet[12:5] flit[4:0]
  task automatic load(input int p, input int len, input int id);
    for (int k = 0; k < len; k++)
      srcq[p].push_back({(k == len - 1), 3'(p), 8'(id), 5'(k)});
    pend[p].push_back(id * 256 + len);
  endtask

  task automatic expect_pkt(input int p, input bit ack);
    int e, id, len;
    e = pend[p].pop_front();
    id = e / 256;
    len = e % 256;
    for (int k = 0; k < len; k++)
      expq.push_back({(ack && k == 0), (k == len - 1), 3'(p), 8'(id), 5'(k)});
  endtask

  task automatic fair_model();
    bit more;
    more = 1'b1;
    while (more) begin
      more = 1'b0;
      for (int off = 1; off <= N; off++) begin
        int p;
        p = (rr_m + off) % N;
        if (!more && pend[p].size() > 0) begin
          expect_pkt(p, 1'b0);
          rr_m = p;
          more = 1'b1;
        end
      end
    end
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (expq.size() > 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, {tag, " drained"}, expq.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk(!out_valid && !ord_ack && in_ready == '0, "R10 reset state",
        {30'd0, out_valid, ord_ack}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // fair mode, every input loaded with two packets
    tag = "R2 R3 full rotation";
    for (int p = 0; p < N; p++) begin
      load(p, p + 1, 10 + p);
      load(p, 3, 20 + p);
    end
    fair_model();
    src_en = 1'b1;
    drain();
    src_en = 1'b0;

    // fair mode, sparse set, single-flit packets, back-pressure
    tag = "R2 R10 sparse with stalls";
    bp = 1'b1;
    load(1, 4, 30); load(1, 4, 31);
    load(3, 1, 32); load(3, 1, 33);
    load(4, 2, 34);
    fair_model();
    src_en = 1'b1;
    drain();
    src_en = 1'b0;
    bp = 1'b0;

    // programmed order stream
    tag = "R4 R5 R6 ordered";
    mode_r = 1'b1;
    for (int p = 0; p < N; p++) load(p, 3, 40 + p);
    load(3, 5, 46);
    ordq.push_back(3'd3); ordq.push_back(3'd1); ordq.push_back(3'd3);
    ordq.push_back(3'd4); ordq.push_back(3'd0); ordq.push_back(3'd2);
    expect_pkt(3, 1'b1); expect_pkt(1, 1'b1); expect_pkt(3, 1'b1);
    expect_pkt(4, 1'b1); expect_pkt(0, 1'b1); expect_pkt(2, 1'b1);
    src_en = 1'b1;
    drain();
    chk(ordq.size() == 0, "R6 every order acknowledged", ordq.size(), 0);

    // programmed, idle while no order or ordered input empty
    tag = "R7 idle";
    load(0, 2, 50);
    load(4, 2, 51);
    repeat (10) @(negedge clk);
    #3 chk(!out_valid, "R7 no order pending", out_valid, 0);
    @(negedge clk);
    ordq.push_back(3'd2);
    repeat (12) @(negedge clk);
    #3 chk(!out_valid && ordq.size() == 1, "R7 ordered input empty",
           {out_valid, 8'(ordq.size())}, 32'd1);
    @(negedge clk);
    load(2, 3, 52);
    ordq.push_back(3'd4); ordq.push_back(3'd0);
    expect_pkt(2, 1'b1); expect_pkt(4, 1'b1); expect_pkt(0, 1'b1);
    drain();

    // illegal order code
    tag = "R8 bad code";
    load(1, 2, 60);
    ordq.push_back(3'd6);
    repeat (15) @(negedge clk);
    #3 chk(!out_valid && ordq.size() == 1, "R8 code 6 ignored",
           {out_valid, 8'(ordq.size())}, 32'd1);
    @(negedge clk);
    ordq.delete();
    ordq.push_back(3'd1);
    expect_pkt(1, 1'b1);
    drain();
    src_en = 1'b0;

    // mode switch in the middle of packets
    tag = "R9 fair to programmed";
    mode_r = 1'b0;
    @(negedge clk);
    load(0, 12, 70);
    fair_model();
    src_en = 1'b1;
    repeat (4) @(negedge clk);
    mode_r = 1'b1;
    load(2, 2, 71);
    drain();
    repeat (4) @(negedge clk);
    #3 chk(!out_valid, "R9 programmed after boundary", out_valid, 0);
    @(negedge clk);
    ordq.push_back(3'd2);
    expect_pkt(2, 1'b1);
    drain();

    tag = "R9 programmed to fair";
    load(3, 10, 72);
    ordq.push_back(3'd3);
    expect_pkt(3, 1'b1);
    repeat (4) @(negedge clk);
    mode_r = 1'b0;
    load(4, 2, 73);
    fair_model();
    drain();
    chk(ordq.size() == 0, "R6 order consumed once", ordq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule